// File: doc/BRIEF.md
# SMBus Slave Message Decoder with Host Notify Routing

This block is the message layer of an SMBus slave on a management link. A bit-level front end, which is not part of this block, reports bus events as one-cycle pulses: start (or repeated start), stop, and each received byte. The decoder answers every byte with an ACK or NACK decision. It recognises three message types only. For a Byte Write it keeps the command and data bytes. For a Byte Read it presents a status byte supplied by the host. For a Host Notify it captures the sender's address and a 16-bit data word.

A received Host Notify sets a sticky status bit. That bit drives exactly one of three level outputs (wake, interrupt, SMI), chosen by three enable inputs. An SMI also sets its own sticky flag. Software clears both flags with write-one-to-clear pulses. The slave address comes out of reset at a usable default and can be rewritten by software.

A message is committed only at its closing stop, and only when it had exactly the expected byte count. Truncated, extended and unknown messages leave every captured register untouched.

Top module: `smb_notify_slave`

## Requirements
- R1: After reset, own_addr equals the DEF_ADDR parameter (default 7'h44). Both status flags, all three route outputs and tx_valid are 0, and the captured registers are 0.
- R2: An address byte is the first byte after a start; bits 7:1 are the address and bit 0 is read (1) or write (0). After a plain start it is ACKed only when it is own_addr with write or 7'h08 (byte 8'h10) with write. After a repeated start that follows a command byte, it is ACKed only when it is own_addr with read. Every other address is NACKed, and every later byte up to the next start is NACKed. When own_addr is 7'h08, the Host Notify meaning takes precedence.
- R3: A Byte Write (start, own address with write, command, data, stop) ACKs all three bytes. In the cycle after the stop, rx_cmd holds the command and rx_data holds the data.
- R4: A Byte Read (start, own address with write, command, repeated start, own address with read) ACKs every byte. In the cycle after the read address, tx_valid is 1 and tx_byte holds the host_status value present at that address byte. tx_valid stays 1 until the next start or stop.
- R5: The slave never takes an error-check byte. A byte after the data byte of a Byte Write, or after the fourth byte of a Host Notify, is NACKed, and that message is discarded.
- R6: Any other sequence updates no captured register and sets no flag. Examples are a stop before the data byte, or a restart with a write address after the command byte.
- R7: A Host Notify (start, 8'h10, sender address, data low, data high, stop) sets notify_sts and loads notify_dev and notify_data ({high, low}) in the cycle after the stop.
- R8: While notify_sts is 1: with en_int=0 and en_wake=0 no output is raised; with en_int=0 and en_wake=1 wake_o is 1; with en_int=1 and en_smi=0 irq_o is 1; with en_int=1 and en_smi=1 smi_o is 1. While notify_sts is 0, all three are 0.
- R9: smi_sts is set when a Host Notify completes while en_int=1 and en_smi=1, and is cleared by a clr_smi pulse.
- R10: notify_sts is cleared by a clr_notify pulse. When a Host Notify completes in the same cycle as a clear pulse, the flag ends set.
- R11: An addr_we pulse loads addr_wdata into own_addr in the next cycle. Later Byte Writes match the new address and NACK the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_byte | input | 1 | A byte has been received |
| byte_in | input | 8 | Received byte |
| ack_o | output | 1 | ACK (1) or NACK (0) for the last byte |
| tx_valid | output | 1 | Read byte is ready to shift out |
| tx_byte | output | 8 | Byte returned by a Byte Read |
| host_status | input | 8 | Status byte offered to readers |
| addr_we | input | 1 | Software write of own address |
| addr_wdata | input | 7 | New own address |
| own_addr | output | 7 | Current own address |
| rx_cmd | output | 8 | Command of last Byte Write |
| rx_data | output | 8 | Data of last Byte Write |
| notify_dev | output | 8 | Sender address of last Host Notify |
| notify_data | output | 16 | Data word of last Host Notify |
| en_int | input | 1 | Interrupt routing enable |
| en_wake | input | 1 | Wake routing enable |
| en_smi | input | 1 | SMI routing enable |
| clr_notify | input | 1 | Write-one-to-clear of notify_sts |
| clr_smi | input | 1 | Write-one-to-clear of smi_sts |
| notify_sts | output | 1 | Host Notify received (status bit 0) |
| smi_sts | output | 1 | Host Notify was routed to SMI |
| wake_o | output | 1 | Wake event |
| irq_o | output | 1 | Interrupt |
| smi_o | output | 1 | SMI |

## Verification
The stop that completes a Host Notify can land in the same cycle as software's write-one-to-clear of the notify flag (and of the SMI flag). The bench provokes this on purpose. It raises clr_notify and clr_smi in the same cycle as the closing stop event, then expects both flags still set and the routed output still raised. A separate directed case checks that a clear with no completing message does drop the flags. Randomised traffic also mixes software clears and enable changes with messages, and a model in the bench predicts the flags and routed outputs after each step.

// File: rtl/smb_notify_slave.sv
module smb_notify_slave #(
  parameter logic [6:0] DEF_ADDR    = 7'h44,
  parameter logic [6:0] NOTIFY_ADDR = 7'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        ev_byte,
  input  logic [7:0]  byte_in,
  output logic        ack_o,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic [7:0]  host_status,
  input  logic        addr_we,
  input  logic [6:0]  addr_wdata,
  output logic [6:0]  own_addr,
  output logic [7:0]  rx_cmd,
  output logic [7:0]  rx_data,
  output logic [7:0]  notify_dev,
  output logic [15:0] notify_data,
  input  logic        en_int,
  input  logic        en_wake,
  input  logic        en_smi,
  input  logic        clr_notify,
  input  logic        clr_smi,
  output logic        notify_sts,
  output logic        smi_sts,
  output logic        wake_o,
  output logic        irq_o,
  output logic        smi_o
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_DATA, S_WDONE,
    S_NDEV, S_NLO, S_NHI, S_NDONE, S_RTX, S_SKIP
  } st_t;

  st_t        st, nxt_st;
  logic       nxt_ack;
  logic       rs_q;
  logic [7:0] cmd_t, data_t, dev_t, lo_t, hi_t;
  logic       notify_hit;

  wire [6:0] a7 = byte_in[7:1];
  wire       rd = byte_in[0];

  always_comb begin
    nxt_st  = S_SKIP;
    nxt_ack = 1'b0;
    case (st)
      S_IDLE: nxt_st = S_IDLE;
      S_ADDR: begin
        if (a7 == NOTIFY_ADDR && !rd && !rs_q) begin
          nxt_st = S_NDEV; nxt_ack = 1'b1;
        end else if (a7 == own_addr && !rd && !rs_q) begin
          nxt_st = S_CMD; nxt_ack = 1'b1;
        end else if (a7 == own_addr && rd && rs_q) begin
          nxt_st = S_RTX; nxt_ack = 1'b1;
        end
      end
      S_CMD:  begin nxt_st = S_DATA;  nxt_ack = 1'b1; end
      S_DATA: begin nxt_st = S_WDONE; nxt_ack = 1'b1; end
      S_NDEV: begin nxt_st = S_NLO;   nxt_ack = 1'b1; end
      S_NLO:  begin nxt_st = S_NHI;   nxt_ack = 1'b1; end
      S_NHI:  begin nxt_st = S_NDONE; nxt_ack = 1'b1; end
      default: ;
    endcase
  end

  assign notify_hit = ev_stop && !ev_start && (st == S_NDONE);
  assign tx_valid   = (st == S_RTX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rs_q        <= 1'b0;
      ack_o       <= 1'b0;
      tx_byte     <= '0;
      own_addr    <= DEF_ADDR;
      cmd_t       <= '0;
      data_t      <= '0;
      dev_t       <= '0;
      lo_t        <= '0;
      hi_t        <= '0;
      rx_cmd      <= '0;
      rx_data     <= '0;
      notify_dev  <= '0;
      notify_data <= '0;
    end else begin
      if (addr_we) own_addr <= addr_wdata;
      if (ev_start) begin
        rs_q <= (st == S_DATA);
        st   <= S_ADDR;
      end else if (ev_stop) begin
        if (st == S_WDONE) begin
          rx_cmd  <= cmd_t;
          rx_data <= data_t;
        end
        if (st == S_NDONE) begin
          notify_dev  <= dev_t;
          notify_data <= {hi_t, lo_t};
        end
        st <= S_IDLE;
      end else if (ev_byte) begin
        ack_o <= nxt_ack;
        st    <= nxt_st;
        case (st)
          S_ADDR: if (nxt_st == S_RTX) tx_byte <= host_status;
          S_CMD:  cmd_t  <= byte_in;
          S_DATA: data_t <= byte_in;
          S_NDEV: dev_t  <= byte_in;
          S_NLO:  lo_t   <= byte_in;
          S_NHI:  hi_t   <= byte_in;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_sts <= 1'b0;
      smi_sts    <= 1'b0;
    end else begin
      if (notify_hit)      notify_sts <= 1'b1;
      else if (clr_notify) notify_sts <= 1'b0;
      if (notify_hit && en_int && en_smi) smi_sts <= 1'b1;
      else if (clr_smi)                   smi_sts <= 1'b0;
    end
  end

  assign wake_o = notify_sts && !en_int && en_wake;
  assign irq_o  = notify_sts && en_int && !en_smi;
  assign smi_o  = notify_sts && en_int && en_smi;

endmodule

// File: rtl/smb_notify_slave_chk.sv
module smb_notify_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_stop,
  input logic        addr_we,
  input logic [6:0]  own_addr,
  input logic [7:0]  rx_data,
  input logic        clr_notify,
  input logic        notify_sts,
  input logic        wake_o,
  input logic        irq_o,
  input logic        smi_o
);

  p_route_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_o, irq_o, smi_o}));

  p_route_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !notify_sts |-> !(wake_o || irq_o || smi_o));

  p_sts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    notify_sts && !clr_notify |=> notify_sts);

  p_sts_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(notify_sts) |-> $past(ev_stop));

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(own_addr));

  p_rx_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $past(ev_stop));

endmodule

bind smb_notify_slave smb_notify_slave_chk u_chk (.*);

// File: tb/smb_notify_slave_bench.sv
module smb_notify_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0;
  logic [7:0] byte_in = 0, host_status = 0;
  logic addr_we = 0;
  logic [6:0] addr_wdata = 0;
  logic en_int = 0, en_wake = 0, en_smi = 0, clr_notify = 0, clr_smi = 0;
  logic ack_o, tx_valid, notify_sts, smi_sts, wake_o, irq_o, smi_o;
  logic [7:0] tx_byte, rx_cmd, rx_data, notify_dev;
  logic [6:0] own_addr;
  logic [15:0] notify_data;

  int checks = 0, errors = 0;
  logic [6:0] m_own = 7'h44;
  logic [7:0] m_cmd = 0, m_data = 0, m_dev = 0;
  logic [15:0] m_nd = 0;
  logic m_nsts = 0, m_ssts = 0;

  always #5 clk = ~clk;

  smb_notify_slave u_smb_notify_slave (.*);

  function automatic logic [2:0] route(logic s, logic i, logic w, logic m);
    if (!s) return 3'b000;
    if (!i) return w ? 3'b001 : 3'b000;
    return m ? 3'b100 : 3'b010;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic do_stop(); ev_stop = 1; @(negedge clk); ev_stop = 0; endtask
  task automatic do_byte(logic [7:0] b, logic exp_ack, string req);
    ev_byte = 1; byte_in = b; @(negedge clk); ev_byte = 0;
    chk(req, ack_o, exp_ack);
  endtask

  task automatic check_all(string req);
    chk({req, " rx_cmd"}, rx_cmd, m_cmd);
    chk({req, " rx_data"}, rx_data, m_data);
    chk({req, " notify_dev"}, notify_dev, m_dev);
    chk({req, " notify_data"}, notify_data, m_nd);
    chk({req, " notify_sts"}, notify_sts, m_nsts);
    chk({req, " smi_sts"}, smi_sts, m_ssts);
    chk({req, " R8 route"}, {smi_o, irq_o, wake_o}, route(m_nsts, en_int, en_wake, en_smi));
  endtask

  task automatic msg_write(logic [6:0] a, logic [7:0] c, logic [7:0] d, bit extra);
    logic ok;
    ok = (a == m_own) && (a != 7'h08);
    do_start();
    do_byte({a, 1'b0}, ok, "R2 write address");
    if (ok) begin
      do_byte(c, 1, "R3 command");
      do_byte(d, 1, "R3 data");
      if (extra) do_byte(8'h5a, 0, "R5 extra byte nack");
    end
    do_stop();
    if (ok && !extra) begin m_cmd = c; m_data = d; end
    check_all(extra ? "R5" : "R3");
  endtask

  task automatic msg_read(logic [7:0] c, logic [7:0] hs);
    do_start();
    do_byte({m_own, 1'b0}, 1, "R4 address write");
    do_byte(c, 1, "R4 command");
    do_start();
    host_status = hs;
    do_byte({m_own, 1'b1}, 1, "R4 address read");
    host_status = ~hs;
    chk("R4 tx_valid", tx_valid, 1);
    chk("R4 tx_byte", tx_byte, hs);
    do_stop();
    chk("R4 tx_valid after stop", tx_valid, 0);
    check_all("R4");
  endtask

  task automatic msg_notify(logic [7:0] dv, logic [7:0] lo, logic [7:0] hi, bit extra, bit clr_same);
    do_start();
    do_byte(8'h10, 1, "R7 notify address");
    do_byte(dv, 1, "R7 sender");
    do_byte(lo, 1, "R7 data low");
    do_byte(hi, 1, "R7 data high");
    if (extra) do_byte(8'hc3, 0, "R5 notify extra nack");
    clr_notify = clr_same; clr_smi = clr_same;
    do_stop();
    clr_notify = 0; clr_smi = 0;
    if (!extra) begin
      m_dev = dv; m_nd = {hi, lo}; m_nsts = 1;
      if (en_int && en_smi) m_ssts = 1;
    end else if (clr_same) begin
      m_nsts = 0; m_ssts = 0;
    end
    check_all(clr_same ? "R10 set beats clear" : (extra ? "R5" : "R7"));
  endtask

  task automatic do_clear(bit cn, bit cs);
    clr_notify = cn; clr_smi = cs; @(negedge clk); clr_notify = 0; clr_smi = 0;
    if (cn) m_nsts = 0;
    if (cs) m_ssts = 0;
    check_all("R10 clear");
  endtask

  task automatic set_addr(logic [6:0] a);
    addr_we = 1; addr_wdata = a; @(negedge clk); addr_we = 0;
    m_own = a;
    chk("R11 own_addr", own_addr, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 own_addr", own_addr, 7'h44);
    chk("R1 tx_valid", tx_valid, 0);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);

    msg_write(7'h44, 8'h12, 8'h34, 0);
    msg_write(7'h45, 8'h99, 8'h99, 0);
    msg_write(7'h44, 8'h56, 8'h78, 1);
    msg_read(8'h01, 8'ha5);
    // R6: stop after the command byte only
    do_start(); do_byte({m_own, 1'b0}, 1, "R6 addr"); do_byte(8'h77, 1, "R6 cmd"); do_stop();
    check_all("R6 truncated");
    // R6: restart with a write address after the command
    do_start(); do_byte({m_own, 1'b0}, 1, "R6 addr"); do_byte(8'h66, 1, "R6 cmd");
    do_start(); do_byte({m_own, 1'b0}, 0, "R6 restart write nack"); do_byte(8'h01, 0, "R6 skip");
    do_stop(); check_all("R6 restart");
    // R2: read address after a plain start
    do_start(); do_byte({m_own, 1'b1}, 0, "R2 read without command"); do_stop();
    // routing table R8 / R9
    en_int = 0; en_wake = 0; en_smi = 0;
    msg_notify(8'h20, 8'h01, 8'h02, 0, 0);
    en_wake = 1; @(negedge clk); check_all("R8 wake");
    en_int = 1; @(negedge clk); check_all("R8 irq");
    do_clear(1, 0);
    en_smi = 1;
    msg_notify(8'h22, 8'h03, 8'h04, 0, 0);
    chk("R9 smi_sts", smi_sts, 1);
    do_clear(1, 1);
    msg_notify(8'h24, 8'h05, 8'h06, 0, 1);
    chk("R10 sts kept", notify_sts, 1);
    msg_notify(8'h26, 8'h07, 8'h08, 1, 0);
    set_addr(7'h31);
    msg_write(7'h44, 8'h01, 8'h02, 0);
    msg_write(7'h31, 8'h0a, 8'h0b, 0);

    for (int i = 0; i < 300; i++) begin
      int k;
      logic [6:0] fa;
      k = $urandom_range(0, 8);
      {en_int, en_wake, en_smi} = 3'($urandom);
      case (k)
        0, 1: msg_write(m_own, 8'($urandom), 8'($urandom), 0);
        2: begin
          fa = 7'($urandom);
          while (fa == m_own || fa == 7'h08) fa = fa + 7'd1;
          msg_write(fa, 8'($urandom), 8'($urandom), 0);
        end
        3: msg_read(8'($urandom), 8'($urandom));
        4: msg_notify(8'($urandom), 8'($urandom), 8'($urandom), 0, 0);
        5: msg_write(m_own, 8'($urandom), 8'($urandom), 1);
        6: msg_notify(8'($urandom), 8'($urandom), 8'($urandom), $urandom_range(0, 1) == 1, 0);
        7: do_clear($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        default: begin
          fa = 7'($urandom);
          if (fa == 7'h08) fa = 7'h09;
          set_addr(fa);
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule